// File: doc/BRIEF.md
# Three-Pin Direction-Programmable Port with Line-Timed Sampling

This block controls a small bank of general-purpose pins. Software chooses, for each pin, whether it is driven by the chip or read from outside. A driven pin carries a value taken from a register. An undriven pin is passed through a two-stage synchroniser, and the result is then held in a capture register that software can read. Because these pins may serve any purpose, their direction and their driven value are always set through registers.

A single sampling-mode bit chooses when the capture register loads. In free-running mode it loads on every system clock. In line-timed mode it loads only on a one-cycle end-of-measuring-line strobe and holds its value between strobes. Pad cells sit outside the block: it hands each pad a driven value and an output-enable, and it receives the pad's input value. The line-timing generator also sits outside and supplies the strobe.

Registers are written through a single-cycle write strobe with an address and data. They are read through a combinational read-data mux. Reset is active-low and asynchronous on entry. Release of reset is synchronised to the clock inside the block.

Top module: `pinport_top`

## Requirements
- R1: After reset, every direction bit, every output-value bit and the sampling-mode bit is 0. As a result, `pin_oe` and `pin_out` are all 0 and the registers at addresses 0, 1 and 2 read back as 0.
- R2: Writing address 0 sets the direction bits, with bit i controlling pin i (1 = output, 0 = input). From the clock edge that takes the write, `pin_oe[i]` equals that bit.
- R3: Writing address 1 sets the output-value bits, with bit i belonging to pin i. From the clock edge that takes the write, `pin_out[i]` equals that bit.
- R4: With sampling-mode bit 0 (address 2, bit 0), a change on `pin_in[i]` of an input pin shows up in readback bit i at address 3 after the third rising edge, and not before.
- R5: With sampling-mode bit 1, the capture register loads only on an edge where `eol_strobe` is high. Between strobes, readback of input pins keeps its last value whatever `pin_in` does.
- R6: For a pin whose direction bit is 1, readback bit i at address 3 returns the value the pin is driving, not `pin_in[i]`.
- R7: Address 3 is read-only. A write to it changes no register. Data bits above the pin count, and above bit 0 for address 2, are discarded on write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register address: 0 direction, 1 output value, 2 sampling mode, 3 pin readback |
| reg_wdata | input | DATA_W (8) | Register write data |
| reg_rdata | output | DATA_W (8) | Combinational read data for `reg_addr` |
| eol_strobe | input | 1 | One-cycle end-of-measuring-line event |
| pin_in | input | NPINS (3) | Values seen at the pads, asynchronous |
| pin_out | output | NPINS (3) | Values to drive onto the pads |
| pin_oe | output | NPINS (3) | Pad output enables, 1 = drive |

## Verification
The assertions assume that `reg_wr`, `reg_addr` and `reg_wdata` hold known values at every rising edge while reset is released. They also assume that `eol_strobe` is never unknown. The pad inputs may change at any time, because they pass through the synchroniser before anything depends on them. The stimulus changes every input only at falling edges and pulses `eol_strobe` for exactly one cycle. It keeps `pin_in` steady for several cycles before any readback that depends on it, so every expected value follows from edge counting alone.

// File: rtl/pinport_pkg.sv
package pinport_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_OVAL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_PINS = 2'd3;
endpackage

// File: rtl/pinport_rst_sync.sv
module pinport_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pinport_sync.sv
module pinport_sync #(
  parameter int unsigned NPINS  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] din,
  output logic [NPINS-1:0] dout
);
  logic [STAGES-1:0][NPINS-1:0] stage_q;
  logic [STAGES-1:0][NPINS-1:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pinport_capture.sv
module pinport_capture #(
  parameter int unsigned NPINS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_mode,
  input  logic             eol_strobe,
  input  logic [NPINS-1:0] din,
  output logic [NPINS-1:0] cap
);
  logic             cap_en;
  logic [NPINS-1:0] cap_d;
  logic [NPINS-1:0] cap_q;

  always_comb begin
    cap_en = !line_mode || eol_strobe;
    cap_d  = cap_en ? din : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= cap_d;
  end

  assign cap = cap_q;

  // R5
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_mode && !eol_strobe) |=> $stable(cap_q))
    else $error("capture changed without a line strobe");
endmodule

// File: rtl/pinport_regs.sv
module pinport_regs
  import pinport_pkg::*;
#(
  parameter int unsigned NPINS  = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NPINS-1:0]  cap,
  output logic [NPINS-1:0]  dir,
  output logic [NPINS-1:0]  oval,
  output logic              line_mode,
  output logic [NPINS-1:0]  pins_rb,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [NPINS-1:0] dir_q,  dir_d;
  logic [NPINS-1:0] oval_q, oval_d;
  logic             mode_q, mode_d;
  logic             wr_dir, wr_oval, wr_mode;

  always_comb begin
    wr_dir  = reg_wr && (reg_addr == ADDR_DIR);
    wr_oval = reg_wr && (reg_addr == ADDR_OVAL);
    wr_mode = reg_wr && (reg_addr == ADDR_MODE);
    dir_d   = wr_dir  ? reg_wdata[NPINS-1:0] : dir_q;
    oval_d  = wr_oval ? reg_wdata[NPINS-1:0] : oval_q;
    mode_d  = wr_mode ? reg_wdata[0]         : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      oval_q <= '0;
      mode_q <= 1'b0;
    end else begin
      dir_q  <= dir_d;
      oval_q <= oval_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    pins_rb   = (dir_q & oval_q) | (~dir_q & cap);
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_DIR:  reg_rdata[NPINS-1:0] = dir_q;
      ADDR_OVAL: reg_rdata[NPINS-1:0] = oval_q;
      ADDR_MODE: reg_rdata[0]         = mode_q;
      default:   reg_rdata[NPINS-1:0] = pins_rb;
    endcase
  end

  assign dir       = dir_q;
  assign oval      = oval_q;
  assign line_mode = mode_q;

  // R7
  ro_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_PINS) |=>
      ($stable(dir_q) && $stable(oval_q) && $stable(mode_q)))
    else $error("write to read-only address changed a register");
endmodule

// File: rtl/pinport_top.sv
module pinport_top
  import pinport_pkg::*;
#(
  parameter int unsigned NPINS       = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eol_strobe,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  logic             rst_q;
  logic [NPINS-1:0] sync_val;
  logic [NPINS-1:0] cap_val;
  logic [NPINS-1:0] dir;
  logic [NPINS-1:0] oval;
  logic             line_mode;
  logic [NPINS-1:0] pins_rb;

  pinport_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_q)
  );

  pinport_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .din(pin_in), .dout(sync_val)
  );

  pinport_capture #(.NPINS(NPINS)) u_cap (
    .clk(clk), .rst_n(rst_q), .line_mode(line_mode),
    .eol_strobe(eol_strobe), .din(sync_val), .cap(cap_val)
  );

  pinport_regs #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_q), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cap(cap_val), .dir(dir), .oval(oval),
    .line_mode(line_mode), .pins_rb(pins_rb), .reg_rdata(reg_rdata)
  );

  assign pin_out = oval;
  assign pin_oe  = dir;

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (reg_wr && reg_addr == ADDR_DIR) |=> (pin_oe == $past(reg_wdata[NPINS-1:0])))
    else $error("output enable does not follow direction write");

  // R4
  free_capture_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !line_mode |=> (cap_val == $past(sync_val)))
    else $error("free-running capture missed synchroniser output");

  // R6
  out_readback_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((pins_rb ^ pin_out) & pin_oe) == '0)
    else $error("readback of driven pin differs from driven value");
endmodule

// File: tb/pinport_top_test.sv
module pinport_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       eol_strobe = 1'b0;
  logic [2:0] pin_in = 3'b000;
  logic [2:0] pin_out;
  logic [2:0] pin_oe;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  pinport_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eol_strobe(eol_strobe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    read_reg(2'd0, v); check("R1 dir", v, 8'h00);
    read_reg(2'd1, v); check("R1 oval", v, 8'h00);
    read_reg(2'd2, v); check("R1 mode", v, 8'h00);
    check("R1 pin_oe", {5'd0, pin_oe}, 8'h00);
    check("R1 pin_out", {5'd0, pin_out}, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] v;
    write_reg(2'd0, 8'h05);
    check("R2 pin_oe", {5'd0, pin_oe}, 8'h05);
    read_reg(2'd0, v); check("R2 dir readback", v, 8'h05);
    write_reg(2'd0, 8'hFA);
    check("R2 pin_oe", {5'd0, pin_oe}, 8'h02);
    read_reg(2'd0, v); check("R7 dir upper bits", v, 8'h02);
  endtask

  task automatic t_output();
    logic [7:0] v;
    pin_in = 3'b101;
    write_reg(2'd0, 8'h07);
    write_reg(2'd1, 8'h02);
    check("R3 pin_out", {5'd0, pin_out}, 8'h02);
    repeat (4) @(negedge clk);
    read_reg(2'd3, v); check("R6 driven readback", v, 8'h02);
    write_reg(2'd1, 8'hFD);
    check("R3 pin_out", {5'd0, pin_out}, 8'h05);
    read_reg(2'd1, v); check("R7 oval upper bits", v, 8'h05);
  endtask

  task automatic t_free_sample();
    logic [7:0] v;
    write_reg(2'd0, 8'h00);
    write_reg(2'd2, 8'h00);
    pin_in = 3'b000;
    repeat (4) @(negedge clk);
    read_reg(2'd3, v); check("R4 settled", v, 8'h00);
    pin_in = 3'b110;
    @(negedge clk);
    @(negedge clk);
    read_reg(2'd3, v); check("R4 before third edge", v, 8'h00);
    @(negedge clk);
    read_reg(2'd3, v); check("R4 after third edge", v, 8'h06);
  endtask

  task automatic t_line_sample();
    logic [7:0] v;
    write_reg(2'd2, 8'hFF);
    read_reg(2'd2, v); check("R7 mode upper bits", v, 8'h01);
    pin_in = 3'b011;
    repeat (5) @(negedge clk);
    read_reg(2'd3, v); check("R5 hold without strobe", v, 8'h06);
    eol_strobe = 1'b1;
    @(negedge clk);
    eol_strobe = 1'b0;
    read_reg(2'd3, v); check("R5 load on strobe", v, 8'h03);
    pin_in = 3'b100;
    repeat (5) @(negedge clk);
    read_reg(2'd3, v); check("R5 hold after strobe", v, 8'h03);
    eol_strobe = 1'b1;
    @(negedge clk);
    eol_strobe = 1'b0;
    read_reg(2'd3, v); check("R5 second strobe", v, 8'h04);
  endtask

  task automatic t_mixed();
    logic [7:0] v;
    write_reg(2'd0, 8'h04);
    write_reg(2'd1, 8'h00);
    pin_in = 3'b111;
    repeat (4) @(negedge clk);
    eol_strobe = 1'b1;
    @(negedge clk);
    eol_strobe = 1'b0;
    read_reg(2'd3, v); check("R6 mixed readback", v, 8'h03);
    write_reg(2'd1, 8'h04);
    read_reg(2'd3, v); check("R6 driven bit follows value", v, 8'h07);
  endtask

  task automatic t_readonly();
    logic [7:0] v;
    write_reg(2'd3, 8'hFF);
    read_reg(2'd0, v); check("R7 dir kept", v, 8'h04);
    read_reg(2'd1, v); check("R7 oval kept", v, 8'h04);
    read_reg(2'd2, v); check("R7 mode kept", v, 8'h01);
    write_reg(2'd2, 8'h00);
    pin_in = 3'b010;
    repeat (3) @(negedge clk);
    read_reg(2'd3, v); check("R4 free mode resumes", v, 8'h06);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_direction();
    t_output();
    t_free_sample();
    t_line_sample();
    t_mixed();
    t_readonly();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule